// File: doc/BRIEF.md
# Serial Configuration Port for a Frequency Synthesizer

This block is the write side of a three-wire serial port that programs a frequency synthesizer. A host drives a serial clock, a serial data line and a latch strobe. While the latch strobe is low, each rising edge of the serial clock shifts one data bit into a 20-bit holding register, most significant bit first. When the latch strobe rises, the two bits shifted in last act as an address. The rest of the word goes to one of three configuration registers: a reference divider, a swallow/main divider pair, or a 16-bit mode word. After each transfer the holding register starts again from zero.

The serial pins are asynchronous to the chip clock. They pass through a synchronizer, and their edges are detected in the chip clock domain. The block also decodes two external power-select pins. From them it forms the transceiver state, the enables for the LO buffers, the receive path and the transmit path, and the synthesizer enable. The synthesizer enable is gated by bit 0 of the mode word. The serial port keeps working in every power state, and the programmed registers keep their values through power-down.

Top module: `syn_ctl_port`

## Requirements
- R1: Data is sampled on rising serial-clock edges, and the first bit sent ends up as the most significant bit of the 20-bit frame word W[19:0].
- R2: Serial-clock edges while the latch strobe is high shift nothing. Configuration registers change only in response to a rising latch strobe.
- R3: The address is W[1:0]. Code 2'b00 loads the reference divider from W[16:2]. Code 2'b01 loads the swallow count from W[8:2] and the main count from W[19:9]. Code 2'b10 loads the mode word from W[17:2].
- R4: A frame with address 2'b11 leaves every register unchanged.
- R5: A frame of fewer than 20 bits reads its missing upper bits as zero, because the holding register is cleared on every transfer. A frame of more than 20 bits keeps only the last 20 bits.
- R6: synth_en equals mode bit 0 AND (pwr_sel1 OR pwr_sel2). lo_en equals pwr_sel1 OR pwr_sel2.
- R7: rx_en is high only when both select pins are 1, and tx_en only when pwr_sel1=1 and pwr_sel2=0. With mode bit 0 set, xcvr_state is 1 for pins 00 (power down), 2 for 11 (receive), 3 for 10 (transmit) and 4 for 01 (idle).
- R8: With mode bit 0 clear, xcvr_state is 0 (disabled) and synth_en is low, whatever the pins are.
- R9: Driving the select pins through power-down and back leaves all configuration registers at their programmed values.
- R10: Synchronous reset clears all registers to zero, so synth_en is low and xcvr_state is 0.
- R11: A transfer changes only the register that its address selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch strobe; shift while low, transfer on its rising edge |
| pwr_sel1 | input | 1 | Power-select pin 1 |
| pwr_sel2 | input | 1 | Power-select pin 2 |
| ref_div | output | R_W | Reference divider value |
| swallow_cnt | output | A_W | Swallow counter value |
| main_cnt | output | B_W | Main counter value |
| mode_word | output | M_W | Mode word; bit 0 gates the synthesizer |
| synth_en | output | 1 | Synthesizer enable |
| lo_en | output | 1 | LO buffer enable |
| rx_en | output | 1 | Receive path enable |
| tx_en | output | 1 | Transmit path enable |
| xcvr_state | output | 3 | Decoded transceiver state code |

## Verification
The assertions assume that the serial pins change slowly relative to the chip clock. Each serial level must be held for several chip cycles, so the synchronizer passes every serial-clock or latch edge as one single-cycle pulse. They also assume that data is stable across the synchronized serial-clock edge. The stimulus keeps each serial level for four chip cycles and changes data only while the serial clock is low. It holds the latch strobe for at least eight cycles around each transfer. Random frames vary in length, address and content, and the power-select pins are re-randomized between them.

// File: rtl/syn_cfg_pkg.sv
package syn_cfg_pkg;

    typedef enum logic [1:0] {
        ADDR_REF  = 2'b00,
        ADDR_AB   = 2'b01,
        ADDR_MODE = 2'b10,
        ADDR_NONE = 2'b11
    } cfg_addr_e;

    typedef enum logic [2:0] {
        ST_DISABLED = 3'd0,
        ST_PWRDN    = 3'd1,
        ST_RX       = 3'd2,
        ST_TX       = 3'd3,
        ST_IDLE     = 3'd4
    } xcvr_state_e;

    localparam int ADDR_W = 2;

endpackage

// File: rtl/syn_ser_sync.sv
module syn_ser_sync #(
    parameter int STAGES = 2,
    parameter int N      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][N-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int k = 1; k < DEPTH; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level_o = st_q.pipe[STAGES-1];
    assign rise_o  = st_q.pipe[STAGES-1] & ~st_q.pipe[STAGES];

    // R1: a detected edge is a single-cycle pulse
    a_r1_rise_pulse: assert property (@(posedge clk) disable iff (rst)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/syn_frame_shift.sv
module syn_frame_shift #(
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_i,
    input  logic               sclk_rise_i,
    input  logic               le_lvl_i,
    input  logic               le_rise_i,
    output logic [FRAME_W-1:0] word_o,
    output logic               commit_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (le_rise_i) begin
            st_d.sh = '0;
        end else if (!le_lvl_i && sclk_rise_i) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o   = st_q.sh;
    assign commit_o = le_rise_i;

    // R2: no shifting while the latch strobe is high
    a_r2_hold_when_latched: assert property (@(posedge clk) disable iff (rst)
        (le_lvl_i && !le_rise_i) |=> $stable(st_q.sh));

endmodule

// File: rtl/syn_cfg_regs.sv
module syn_cfg_regs
    import syn_cfg_pkg::*;
#(
    parameter int FRAME_W = 20,
    parameter int R_W     = 15,
    parameter int A_W     = 7,
    parameter int B_W     = 11,
    parameter int M_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               commit_i,
    output logic [R_W-1:0]     rdiv_o,
    output logic [A_W-1:0]     acnt_o,
    output logic [B_W-1:0]     bcnt_o,
    output logic [M_W-1:0]     mode_o
);
    localparam int A_LSB = ADDR_W;
    localparam int B_LSB = ADDR_W + A_W;

    typedef struct packed {
        logic [R_W-1:0] rdiv;
        logic [A_W-1:0] acnt;
        logic [B_W-1:0] bcnt;
        logic [M_W-1:0] mode;
    } regs_t;

    regs_t st_d, st_q;
    cfg_addr_e addr;

    assign addr = cfg_addr_e'(word_i[ADDR_W-1:0]);

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            unique case (addr)
                ADDR_REF:  st_d.rdiv = word_i[ADDR_W +: R_W];
                ADDR_AB: begin
                    st_d.acnt = word_i[A_LSB +: A_W];
                    st_d.bcnt = word_i[B_LSB +: B_W];
                end
                ADDR_MODE: st_d.mode = word_i[ADDR_W +: M_W];
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdiv_o = st_q.rdiv;
    assign acnt_o = st_q.acnt;
    assign bcnt_o = st_q.bcnt;
    assign mode_o = st_q.mode;

    // R4: unused address leaves every register untouched
    a_r4_unused_addr: assert property (@(posedge clk) disable iff (rst)
        (commit_i && word_i[1:0] == 2'b11) |=> $stable(st_q));

    // R2: without a transfer nothing changes
    a_r2_no_transfer_hold: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(st_q));

    // R11: a reference transfer leaves the other registers alone
    a_r11_ref_only: assert property (@(posedge clk) disable iff (rst)
        (commit_i && word_i[1:0] == 2'b00) |=>
            ($stable(st_q.acnt) && $stable(st_q.bcnt) && $stable(st_q.mode)));

endmodule

// File: rtl/syn_ctl_port.sv
module syn_ctl_port
    import syn_cfg_pkg::*;
#(
    parameter int FRAME_W     = 20,
    parameter int R_W         = 15,
    parameter int A_W         = 7,
    parameter int B_W         = 11,
    parameter int M_W         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_latch,
    input  logic           pwr_sel1,
    input  logic           pwr_sel2,
    output logic [R_W-1:0] ref_div,
    output logic [A_W-1:0] swallow_cnt,
    output logic [B_W-1:0] main_cnt,
    output logic [M_W-1:0] mode_word,
    output logic           synth_en,
    output logic           lo_en,
    output logic           rx_en,
    output logic           tx_en,
    output logic [2:0]     xcvr_state
);
    localparam int IDX_DATA  = 0;
    localparam int IDX_SCLK  = 1;
    localparam int IDX_LATCH = 2;

    logic [2:0]         ser_lvl, ser_rise;
    logic [FRAME_W-1:0] frame_word;
    logic               frame_commit;
    xcvr_state_e        state_d;

    syn_ser_sync #(.STAGES(SYNC_STAGES), .N(3)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_latch, ser_clk, ser_data}),
        .level_o (ser_lvl),
        .rise_o  (ser_rise)
    );

    syn_frame_shift #(.FRAME_W(FRAME_W)) i_shift (
        .clk         (clk),
        .rst         (rst),
        .bit_i       (ser_lvl[IDX_DATA]),
        .sclk_rise_i (ser_rise[IDX_SCLK]),
        .le_lvl_i    (ser_lvl[IDX_LATCH]),
        .le_rise_i   (ser_rise[IDX_LATCH]),
        .word_o      (frame_word),
        .commit_o    (frame_commit)
    );

    syn_cfg_regs #(
        .FRAME_W (FRAME_W),
        .R_W     (R_W),
        .A_W     (A_W),
        .B_W     (B_W),
        .M_W     (M_W)
    ) i_regs (
        .clk      (clk),
        .rst      (rst),
        .word_i   (frame_word),
        .commit_i (frame_commit),
        .rdiv_o   (ref_div),
        .acnt_o   (swallow_cnt),
        .bcnt_o   (main_cnt),
        .mode_o   (mode_word)
    );

    always_comb begin
        lo_en    = pwr_sel1 | pwr_sel2;
        synth_en = mode_word[0] & lo_en;
        rx_en    = pwr_sel1 & pwr_sel2;
        tx_en    = pwr_sel1 & ~pwr_sel2;
        if (!mode_word[0]) begin
            state_d = ST_DISABLED;
        end else begin
            unique case ({pwr_sel1, pwr_sel2})
                2'b00:   state_d = ST_PWRDN;
                2'b11:   state_d = ST_RX;
                2'b10:   state_d = ST_TX;
                default: state_d = ST_IDLE;
            endcase
        end
        xcvr_state = state_d;
    end

    // R6: the synthesizer never runs without mode bit 0
    a_r6_en_needs_mode: assert property (@(posedge clk) disable iff (rst)
        synth_en |-> mode_word[0]);

    // R7: receive and transmit are never enabled together
    a_r7_rx_tx_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_en, tx_en}));

    // R10: right after reset the synthesizer is off
    a_r10_reset_off: assert property (@(posedge clk)
        $past(rst) |-> !synth_en);

endmodule

// File: tb/test_syn_ctl_port.sv
`timescale 1ns/1ps
module test_syn_ctl_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_latch = 1'b1;
    logic        pwr_sel1 = 1'b0;
    logic        pwr_sel2 = 1'b0;
    logic [14:0] ref_div;
    logic [6:0]  swallow_cnt;
    logic [10:0] main_cnt;
    logic [15:0] mode_word;
    logic        synth_en, lo_en, rx_en, tx_en;
    logic [2:0]  xcvr_state;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [14:0] exp_r = '0;
    logic [6:0]  exp_a = '0;
    logic [10:0] exp_b = '0;
    logic [15:0] exp_m = '0;

    always #2.5 clk = ~clk;

    syn_ctl_port i_syn_ctl_port (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .pwr_sel1(pwr_sel1), .pwr_sel2(pwr_sel2),
        .ref_div(ref_div), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
        .mode_word(mode_word), .synth_en(synth_en), .lo_en(lo_en),
        .rx_en(rx_en), .tx_en(tx_en), .xcvr_state(xcvr_state)
    );

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] frame_eff(input logic [31:0] w, input int n);
        if (n >= 20) return w[19:0];
        return w[19:0] & ((20'd1 << n) - 20'd1);
    endfunction

    function automatic logic [2:0] exp_state(input logic m0, input logic p1, input logic p2);
        if (!m0) return 3'd0;
        case ({p1, p2})
            2'b00:   return 3'd1;
            2'b11:   return 3'd2;
            2'b10:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    task automatic apply_model(input logic [19:0] e);
        case (e[1:0])
            2'b00: exp_r = e[16:2];
            2'b01: begin exp_a = e[8:2]; exp_b = e[19:9]; end
            2'b10: exp_m = e[17:2];
            default: ;
        endcase
    endtask

    task automatic send(input logic [31:0] w, input int n);
        ser_latch = 1'b0;
        cyc(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            cyc(4);
            ser_clk = 1'b1;
            cyc(4);
            ser_clk = 1'b0;
        end
        cyc(4);
        ser_latch = 1'b1;
        cyc(8);
        apply_model(frame_eff(w, n));
    endtask

    task automatic check_regs(input string tag);
        check_val({tag, " ref_div"},     32'(ref_div),     32'(exp_r));
        check_val({tag, " swallow_cnt"}, 32'(swallow_cnt), 32'(exp_a));
        check_val({tag, " main_cnt"},    32'(main_cnt),    32'(exp_b));
        check_val({tag, " mode_word"},   32'(mode_word),   32'(exp_m));
    endtask

    task automatic check_pwr(input string tag, input logic p1, input logic p2);
        pwr_sel1 = p1;
        pwr_sel2 = p2;
        cyc(1);
        check_val({tag, " R6 synth_en"}, 32'(synth_en), 32'(exp_m[0] & (p1 | p2)));
        check_val({tag, " R6 lo_en"},    32'(lo_en),    32'(p1 | p2));
        check_val({tag, " R7 rx_en"},    32'(rx_en),    32'(p1 & p2));
        check_val({tag, " R7 tx_en"},    32'(tx_en),    32'(p1 & ~p2));
        check_val({tag, " R7 state"},    32'(xcvr_state), 32'(exp_state(exp_m[0], p1, p2)));
    endtask

    initial begin
        void'($urandom(32'd1234));
        cyc(10);
        rst = 1'b0;
        cyc(10);
        // R10: reset state
        check_regs("R10 reset");
        check_pwr("R10 R8 reset pins11", 1'b1, 1'b1);
        check_pwr("R10 reset pins00", 1'b0, 1'b0);

        // R1 R3: directed writes to each register, R11: others unchanged
        send({15'h5ABC, 2'b00} | 32'h0, 20);
        check_regs("R1 R3 R11 ref write");
        send({11'h6D3, 7'h2A, 2'b01}, 20);
        check_regs("R3 R11 ab write");
        send({2'b11, 16'hA5C3, 2'b10}, 20);
        check_regs("R3 R11 mode write");

        // R6 R7: all pin combinations with mode bit 0 set
        check_pwr("R6 R7 pins00", 1'b0, 1'b0);
        check_pwr("R6 R7 pins01", 1'b0, 1'b1);
        check_pwr("R6 R7 pins10", 1'b1, 1'b0);
        check_pwr("R6 R7 pins11", 1'b1, 1'b1);

        // R9: power down and back, registers retained
        check_pwr("R9 down", 1'b0, 1'b0);
        cyc(20);
        check_pwr("R9 up", 1'b1, 1'b1);
        check_regs("R9 retained");

        // R4: unused address discarded
        send({18'h3FFFF, 2'b11}, 20);
        check_regs("R4 unused addr");

        // R2: serial clocks while latch high are ignored; R5 short frame
        ser_data = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cyc(4); ser_clk = 1'b1; cyc(4); ser_clk = 1'b0;
        end
        cyc(4);
        check_regs("R2 clocks while latched");
        send({8'hC7, 2'b00}, 10);
        check_regs("R2 R5 short ref frame");

        // R5: long frame keeps last 20 bits
        send({4'hF, 7'h55, 11'h0F0, 2'b01} | 32'h0, 24);
        check_regs("R5 long frame");

        // R8: mode bit 0 cleared disables regardless of pins
        send({2'b00, 16'hFFFE, 2'b10}, 20);
        check_regs("R8 mode clear");
        check_pwr("R8 pins11", 1'b1, 1'b1);
        check_pwr("R8 pins10", 1'b1, 1'b0);

        // Random frames: R1 R3 R4 R5 R11, random pins: R6 R7 R8
        for (int t = 0; t < 60; t++) begin
            logic [31:0] w;
            int n;
            w = $urandom();
            n = 8 + int'($urandom_range(16));
            send(w, n);
            check_regs("R3 R5 R11 random frame");
            check_pwr("R6 R7 R8 random pins", 1'($urandom()), 1'($urandom()));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule